// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Timer

This block produces four pulse-width-modulated outputs from one clock. A simple write-strobe register port sets up each channel. The clock first goes through an 8-bit prescaler. Channels 0 and 1 share one prescaler, and channels 2 and 3 share the other. Each channel then has its own clock divider, selected by a small code. The divided rate steps a 16-bit down-counter. A channel's output is high while its counter is at or below the channel's compare value.

Each channel has a run bit and a repeat bit. With repeat set, the counter reloads its period when it passes zero, so the waveform runs continuously. With repeat clear, the channel produces a single period and then stays low. New period and compare values are taken up only when the counter loads. A prescaler field of zero freezes both channels of its pair and holds their outputs low.

Top module: `quad_pwm_timer`

## Requirements
- R1: After reset all outputs are low and every register reads as zero.
- R2: Register map (byte addresses) and readback:
  - 0x00 holds the prescalers: bits [7:0] serve channels 0 and 1, bits [15:8] serve channels 2 and 3.
  - 0x04 holds a 3-bit divider code per channel at bits [4*ch+2:4*ch].
  - 0x08 is the control register. Channel 0 has run at bit 0 and repeat at bit 3. Channel ch ≥ 1 has run at bit 4+4*ch and repeat at bit 7+4*ch.
  - Each channel's period is at 0x0C+0x0C*ch and its compare value at 0x10+0x0C*ch, both bits [15:0].
  - A write takes effect at the clock edge where the strobe is high. Reads are combinational. Unused bits and unmapped or misaligned addresses read as zero.
- R3: A nonzero prescaler field P makes the channels of its pair advance at most once every P+1 clocks.
- R4: Divider code 4 divides by 1, 0 by 2, 1 by 4, 2 by 8 and 3 by 16. Codes 5, 6 and 7 divide by 1.
- R5: With run and repeat set, let S = (P+1) × divider. The output period is (period+1)×S clocks, and it is high for (compare+1)×S clocks of each period.
- R6: A compare value greater than or equal to the period keeps a repeating channel's output high without a break.
- R7: With repeat clear, a channel produces exactly one period after run is set. It then stays low until run is cleared and set again.
- R8: Compare and period writes made while a channel runs change nothing until the counter next loads.
- R9: While a prescaler field is zero, both outputs of its pair stay low and their counters hold. The other pair is not affected.
- R10: Clearing a run bit drives that output low in the cycle after the write edge and clears the counter. Setting run again starts from a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 4 | PWM outputs, bit n is channel n |

## Verification
A register write shows on the read port in the cycle right after its strobe edge. A cleared run bit pulls the output low in that same following cycle. The bench samples both at the first falling edge after the write.

A channel's first step after it starts depends on the free-running prescaler phase. For that reason, period and high time are measured from one output rising edge to the next. One-shot pulses are counted as total high cycles over a long window, and the low stretch after a restart is checked against a narrow window.

Halting and shadowing are checked by counting high cycles over fixed windows. For shadowing, the check is that the high time still left after a mid-period write is longer than the new compare value would allow.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

  localparam logic [7:0] OFS_PRESC = 8'h00;
  localparam logic [7:0] OFS_DSEL  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;

  // byte address of a channel's period register
  function automatic logic [7:0] period_ofs(input int ch);
    return 8'(12 + 12 * ch);
  endfunction

  // byte address of a channel's compare register
  function automatic logic [7:0] compare_ofs(input int ch);
    return 8'(16 + 12 * ch);
  endfunction

  // control bit holding run-enable for a channel
  function automatic int run_bit(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  // control bit holding repeat (auto-reload) for a channel
  function automatic int rpt_bit(input int ch);
    return run_bit(ch) + 3;
  endfunction

  // mask of all implemented control bits
  function automatic logic [31:0] ctrl_mask(input int nch);
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < nch; c++) begin
      m[run_bit(c)] = 1'b1;
      m[rpt_bit(c)] = 1'b1;
    end
    return m;
  endfunction

  // log2 of the divide ratio selected by a divider code
  function automatic int div_log2(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      default: return 0;
    endcase
  endfunction

  // last value of the divider counter before a step
  function automatic logic [3:0] div_last(input logic [2:0] code);
    return 4'((5'd1 << div_log2(code)) - 5'd1);
  endfunction

endpackage

// File: rtl/pwm_timer_regs.sv
`timescale 1ns/1ps
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int NPAIR = NCH / 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_stb,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NPAIR-1:0][PRE_W-1:0]      presc_o,
  output logic [NCH-1:0][SEL_W-1:0]        dsel_o,
  output logic [NCH-1:0]                   run_o,
  output logic [NCH-1:0]                   rpt_o,
  output logic [NCH-1:0][CNT_W-1:0]        period_o,
  output logic [NCH-1:0][CNT_W-1:0]        compare_o
);

  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(ctrl_mask(NCH));

  logic              hit_presc, hit_dsel, hit_ctrl;
  logic [DATA_W-1:0] ctl_word;

  assign hit_presc = (addr == ADDR_W'(OFS_PRESC));
  assign hit_dsel  = (addr == ADDR_W'(OFS_DSEL));
  assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
  assign ctl_word  = wdata & CTL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_o   <= '0;
      dsel_o    <= '0;
      run_o     <= '0;
      rpt_o     <= '0;
      period_o  <= '0;
      compare_o <= '0;
    end else if (wr_stb) begin
      for (int p = 0; p < NPAIR; p++) begin
        if (hit_presc) presc_o[p] <= wdata[p*PRE_W +: PRE_W];
      end
      for (int c = 0; c < NCH; c++) begin
        if (hit_dsel) dsel_o[c] <= wdata[4*c +: SEL_W];
        if (hit_ctrl) begin
          run_o[c] <= ctl_word[run_bit(c)];
          rpt_o[c] <= ctl_word[rpt_bit(c)];
        end
        if (addr == ADDR_W'(period_ofs(c)))  period_o[c]  <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(compare_ofs(c))) compare_o[c] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_presc) begin
      for (int p = 0; p < NPAIR; p++) rdata[p*PRE_W +: PRE_W] = presc_o[p];
    end
    if (hit_dsel) begin
      for (int c = 0; c < NCH; c++) rdata[4*c +: SEL_W] = dsel_o[c];
    end
    if (hit_ctrl) begin
      for (int c = 0; c < NCH; c++) begin
        rdata[run_bit(c)] = run_o[c];
        rdata[rpt_bit(c)] = rpt_o[c];
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(period_ofs(c)))  rdata[CNT_W-1:0] = period_o[c];
      if (addr == ADDR_W'(compare_ofs(c))) rdata[CNT_W-1:0] = compare_o[c];
    end
  end

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(run_o) && $stable(rpt_o))); // R2

endmodule

// File: rtl/pwm_timer_presc.sv
`timescale 1ns/1ps
module pwm_timer_presc #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] presc,
  output logic             tick,
  output logic             halt
);

  logic [PRE_W-1:0] pcnt;

  assign halt = (presc == '0);
  assign tick = !halt && (pcnt >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt <= '0;
    else if (halt | tick) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

endmodule

// File: rtl/pwm_timer_chan.sv
`timescale 1ns/1ps
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rpt,
  input  logic [SEL_W-1:0] dsel,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  input  logic             tick,
  input  logic             halt,
  output logic             pwm_o
);

  localparam int DIVC_W = 4;

  logic              run_q, active;
  logic [CNT_W-1:0]  cnt, cmp_act;
  logic [DIVC_W-1:0] div_cnt;
  logic              div_hit, step, start, at_zero;

  assign div_hit = (div_cnt >= div_last(3'(dsel)));
  assign step    = active & tick & div_hit;
  assign start   = run & ~run_q;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      cmp_act <= '0;
      div_cnt <= '0;
    end else begin
      run_q <= run;
      if (!run) begin
        active  <= 1'b0;
        cnt     <= '0;
        div_cnt <= '0;
      end else if (start) begin
        active  <= 1'b1;
        cnt     <= period;
        cmp_act <= compare;
        div_cnt <= '0;
      end else if (active && tick) begin
        if (div_hit) begin
          div_cnt <= '0;
          if (at_zero) begin
            if (rpt) begin
              cnt     <= period;
              cmp_act <= compare;
            end else begin
              active <= 1'b0;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign pwm_o = run & active & ~halt & (cnt <= cmp_act);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!active && cnt == '0)); // R10

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !at_zero) |=> (cnt == $past(cnt) - 1'b1)); // R5

  AST_ONE_SHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && at_zero && !rpt) |=> !active); // R7

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !(step && at_zero)) |=> $stable(cmp_act)); // R8

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && run && run_q) |=> $stable(cnt)); // R9

endmodule

// File: rtl/quad_pwm_timer.sv
`timescale 1ns/1ps
module quad_pwm_timer #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int NPAIR = NCH / 2;

  logic [NPAIR-1:0][PRE_W-1:0] presc;
  logic [NCH-1:0][SEL_W-1:0]   dsel;
  logic [NCH-1:0]              run, rpt;
  logic [NCH-1:0][CNT_W-1:0]   period, compare;
  logic [NPAIR-1:0]            tick, halt;

  pwm_timer_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .presc_o(presc), .dsel_o(dsel),
    .run_o(run), .rpt_o(rpt), .period_o(period), .compare_o(compare)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_timer_presc #(.PRE_W(PRE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .presc(presc[p]),
      .tick(tick[p]), .halt(halt[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_timer_chan #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(run[c]), .rpt(rpt[c]),
      .dsel(dsel[c]), .period(period[c]), .compare(compare[c]),
      .tick(tick[c/2]), .halt(halt[c/2]), .pwm_o(pwm_out[c])
    );
  end

endmodule

// File: tb/sim_quad_pwm_timer.sv
`timescale 1ns/1ps
module sim_quad_pwm_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] ctrl_img = '0;
  logic [31:0] dsel_img = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  function automatic int en_pos(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_stb = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, a, rdata, exp);
    end
    addr = '0;
  endtask

  task automatic setup(input int ch, input int per, input int cmp, input int code, input bit rpt);
    ctrl_img[en_pos(ch)] = 1'b0;
    ctrl_img[en_pos(ch)+3] = 1'b0;
    wr(8'h08, ctrl_img);
    wr(8'(12 + 12*ch), 32'(per));
    wr(8'(16 + 12*ch), 32'(cmp));
    dsel_img[4*ch +: 3] = 3'(code);
    wr(8'h04, dsel_img);
    ctrl_img[en_pos(ch)] = 1'b1;
    ctrl_img[en_pos(ch)+3] = rpt;
    wr(8'h08, ctrl_img);
  endtask

  // waits for a rising edge, then counts one period up to the next rising edge
  task automatic measure(input int ch, output int per_c, output int hi_c);
    int guard = 0;
    logic prev = 1'b1;
    per_c = 0; hi_c = 0;
    while (guard < 4000) begin
      @(negedge clk); guard++;
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
    prev = 1'b1;
    while (guard < 4000) begin
      hi_c += int'(pwm_out[ch]);
      per_c++;
      prev = pwm_out[ch];
      @(negedge clk); guard++;
      if (!prev && pwm_out[ch]) break;
    end
  endtask

  task automatic count_hi(input int ch, input int n, output int hi_c);
    hi_c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi_c += int'(pwm_out[ch]);
    end
  endtask

  task automatic t_reset;
    check("R1 outputs after reset", int'(pwm_out), 0);
    rd_chk("R1 prescaler reset", 8'h00, 32'h0);
    rd_chk("R1 divider reset", 8'h04, 32'h0);
    rd_chk("R1 control reset", 8'h08, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd_chk("R1 period reset", 8'(12 + 12*c), 32'h0);
      rd_chk("R1 compare reset", 8'(16 + 12*c), 32'h0);
    end
  endtask

  task automatic t_regs;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_1234);
    wr(8'h34, 32'hABCD_8765);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R2 prescaler mask", 8'h00, 32'h0000_FFFF);
    rd_chk("R2 divider mask", 8'h04, 32'h0000_7777);
    rd_chk("R2 control bit positions", 8'h08, 32'h0009_9909);
    rd_chk("R2 period ch1", 8'h18, 32'h0000_1234);
    rd_chk("R2 compare ch3", 8'h34, 32'h0000_8765);
    rd_chk("R2 unmapped", 8'h38, 32'h0);
    rd_chk("R2 misaligned", 8'h19, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h34, 32'h0);
    rd_chk("R2 control cleared", 8'h08, 32'h0);
  endtask

  task automatic t_divider;
    int codes[7] = '{4, 0, 1, 2, 3, 5, 7};
    int ratio[7] = '{1, 2, 4, 8, 16, 1, 1};
    int pc, hc;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0101);
    for (int i = 0; i < 7; i++) begin
      setup(0, 3, 1, codes[i], 1'b1);
      measure(0, pc, hc);
      check($sformatf("R4 R5 period code %0d", codes[i]), pc, 4 * 2 * ratio[i]);
      check($sformatf("R4 R5 high code %0d", codes[i]), hc, 2 * 2 * ratio[i]);
    end
  endtask

  task automatic t_share;
    int pc, hc;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0103);
    setup(0, 3, 1, 4, 1'b1);
    setup(1, 3, 1, 4, 1'b1);
    setup(2, 3, 1, 4, 1'b1);
    measure(0, pc, hc);
    check("R3 ch0 period with shared x4", pc, 16);
    check("R3 ch0 high with shared x4", hc, 8);
    measure(1, pc, hc);
    check("R3 ch1 period with shared x4", pc, 16);
    check("R3 ch1 high with shared x4", hc, 8);
    measure(2, pc, hc);
    check("R3 ch2 period on other pair x2", pc, 8);
    check("R3 ch2 high on other pair x2", hc, 4);
    setup(3, 6, 2, 0, 1'b1);
    measure(3, pc, hc);
    check("R5 ch3 period 7 steps x4", pc, 28);
    check("R5 ch3 high 3 steps x4", hc, 12);
  endtask

  task automatic t_full;
    int hc;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0101);
    setup(0, 3, 7, 4, 1'b1);
    repeat (3) @(negedge clk);
    count_hi(0, 100, hc);
    check("R6 compare above period stays high", hc, 100);
    setup(0, 3, 3, 4, 1'b1);
    repeat (3) @(negedge clk);
    count_hi(0, 100, hc);
    check("R6 compare equal period stays high", hc, 100);
  endtask

  task automatic t_oneshot;
    int h1, h2;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0101);
    setup(0, 20, 3, 4, 1'b0);
    wr(8'h10, 32'd10);
    count_hi(0, 100, h1);
    count_hi(0, 200, h2);
    check("R8 one-shot keeps compare latched at start", h1, 8);
    check("R7 one-shot stays low after its period", h2, 0);
  endtask

  task automatic t_shadow;
    int pc, hc, guard;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0101);
    setup(1, 7, 3, 4, 1'b1);
    measure(1, pc, hc);
    check("R5 ch1 period before change", pc, 16);
    // measure returns at a fresh rising edge: write new values now
    wr(8'h1C, 32'd0);
    wr(8'h18, 32'd3);
    hc = 0; guard = 0;
    while (pwm_out[1] && guard < 100) begin
      hc++; guard++;
      @(negedge clk);
    end
    check_rng("R8 old compare holds until reload", hc, 3, 8);
    measure(1, pc, hc);
    check("R8 new period after reload", pc, 8);
    check("R8 new compare after reload", hc, 2);
  endtask

  task automatic t_halt;
    int hc, pc;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0100);
    setup(0, 3, 3, 4, 1'b1);
    setup(1, 3, 1, 4, 1'b1);
    setup(2, 3, 1, 4, 1'b1);
    count_hi(0, 200, hc);
    check("R9 ch0 silent with zero prescaler", hc, 0);
    count_hi(1, 100, hc);
    check("R9 ch1 silent with zero prescaler", hc, 0);
    measure(2, pc, hc);
    check("R9 other pair keeps running", pc, 8);
  endtask

  task automatic t_disable;
    int pc, hc, lows;
    ctrl_img = '0; wr(8'h08, ctrl_img);
    wr(8'h00, 32'h0000_0101);
    setup(0, 5, 1, 4, 1'b1);
    measure(0, pc, hc);
    ctrl_img = '0;
    wr(8'h08, ctrl_img);
    check("R10 output low right after clearing run", int'(pwm_out[0]), 0);
    rd_chk("R10 run bit reads clear", 8'h08, 32'h0);
    ctrl_img[0] = 1'b1; ctrl_img[3] = 1'b1;
    wr(8'h08, ctrl_img);
    lows = 0;
    while (!pwm_out[0] && lows < 100) begin
      lows++;
      @(negedge clk);
    end
    check_rng("R10 restart low stretch from full period", lows, 7, 10);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_divider();
    t_share();
    t_full();
    t_oneshot();
    t_shadow();
    t_halt();
    t_disable();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule